// File: doc/BRIEF.md
# Preemption-Aware Next-Interrupt Selector

This block sits beside the storage arrays of an external interrupt controller. Each cycle it takes the pending, enable and per-line priority vectors, along with two preemption levels: the level now in force and the level that was in force before the current handler began. From these inputs it produces two results. The first is the single machine external interrupt pending flag that goes to the core. The second is the word software gets when it reads the get-next-interrupt register.

The get-next word holds the index of the best eligible line, shifted left by two so it can index a table of 32-bit handler pointers. When no line qualifies, the top bit of the word is set. Both results are registered once, so they are stable for a register read in the following cycle.

When software reads a word that names a real line, the block pulses a clear for that line's software-force bit. If the read also carries the update bit, the block also pulses a request to the context logic to raise its preemption level.

Top module: `irqsel_top`

## Requirements
- R1: A line is a candidate only when its pending bit and its enable bit are both 1. A pending line that is not enabled never affects either output.
- R2: `extIrqPending` is 1 in the cycle after a clock edge at which some candidate's priority was greater than or equal to `curLevel`. Otherwise it is 0.
- R3: The get-next word ignores every candidate whose priority is below `prevLevel`. This holds even when that candidate is at or above `curLevel`.
- R4: Among eligible candidates, the one with the numerically highest priority wins. When several share the highest priority, the lowest index wins.
- R5: When there is a winner, `nextWord` carries the winner's index in bits starting at bit 2. All other bits are 0, including bit 31 and bits 1:0. The word appears one cycle after the inputs are sampled.
- R6: When there is no eligible candidate, `nextWord` is exactly 32'h8000_0000.
- R7: While `readStb` is 1 and `nextWord[31]` is 0, `forceClr` is 1 in the same cycle and `forceClrIdx` equals the index in `nextWord`. While bit 31 is 1, or no read is in progress, `forceClr` is 0 and `forceClrIdx` is 0.
- R8: `raiseLevel` is 1 exactly when `forceClr` is 1 and `updateBit` is 1.
- R9: During and immediately after reset, `nextWord` is 32'h8000_0000 and `extIrqPending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_IRQ | Pending bit per line |
| enableVec | input | NUM_IRQ | Enable bit per line |
| prioVec | input | NUM_IRQ*PRIO_W | Priority of line k at bits [k*PRIO_W +: PRIO_W] |
| curLevel | input | PRIO_W | Preemption level now in force |
| prevLevel | input | PRIO_W | Preemption level of the interrupted frame |
| readStb | input | 1 | Software is reading the get-next word this cycle |
| updateBit | input | 1 | Bit 0 of the write data that accompanies the read |
| extIrqPending | output | 1 | Registered machine external interrupt pending flag |
| nextWord | output | 32 | Registered get-next word |
| forceClr | output | 1 | Clear strobe for one force bit |
| forceClrIdx | output | $clog2(NUM_IRQ) | Line whose force bit is cleared |
| raiseLevel | output | 1 | Request to raise the preemption level |

## Verification
The assertions assume that the input vectors and levels carry known values at every clock edge, and that `readStb` and `updateBit` are meaningful only as same-cycle qualifiers of the registered word. Under those assumptions, the winner named in the word can be traced back to inputs sampled one edge earlier. To stay within these assumptions, the stimulus changes every input only on the falling edge and holds it across at least one rising edge before sampling. It raises the read strobe only after the word has settled.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int MAX_PRIO_W = 4;
  localparam int MAX_IDX_W  = 9;
  localparam logic [31:0] NO_IRQ_WORD = 32'h8000_0000;

  typedef struct packed {
    logic                  valid;
    logic [MAX_PRIO_W-1:0] prio;
    logic [MAX_IDX_W-1:0]  idx;
  } cand_t;

  typedef struct packed {
    logic clrForce;
    logic raise;
  } selStrobe_t;
endpackage

// File: rtl/irqsel_datapath.sv
module irqsel_datapath
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ-1:0]        enableVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioVec,
  input  logic [PRIO_W-1:0]         curLevel,
  input  logic [PRIO_W-1:0]         prevLevel,
  input  selStrobe_t                strobes,
  output logic [31:0]               nextWord,
  output logic                      extPend,
  output logic [$clog2(NUM_IRQ)-1:0] clrIdx
);
  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int LEAVES = 1 << IDX_W;
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t tree [NODES];

  // leaf stage: eligibility against the previous level
  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_IRQ) begin : g_real
      logic [PRIO_W-1:0] linePrio;
      assign linePrio = prioVec[k*PRIO_W +: PRIO_W];
      assign tree[LEAVES-1+k].valid = pendVec[k] & enableVec[k] & (linePrio >= prevLevel);
      assign tree[LEAVES-1+k].prio  = MAX_PRIO_W'(linePrio);
      assign tree[LEAVES-1+k].idx   = MAX_IDX_W'(k);
    end else begin : g_pad
      assign tree[LEAVES-1+k] = '0;
    end
  end

  // comparator tree: left child holds the lower indices, so ties go left
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    cand_t lhs, rhs;
    assign lhs = tree[2*n+1];
    assign rhs = tree[2*n+2];
    assign tree[n] = (lhs.valid && (!rhs.valid || lhs.prio >= rhs.prio)) ? lhs : rhs;
  end

  logic pendAny;
  always_comb begin
    pendAny = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pendVec[i] && enableVec[i] && (prioVec[i*PRIO_W +: PRIO_W] >= curLevel))
        pendAny = 1'b1;
    end
  end

  logic [31:0] wordNext;
  always_comb begin
    wordNext = '0;
    if (tree[0].valid) wordNext[2 +: IDX_W] = tree[0].idx[IDX_W-1:0];
    else               wordNext = NO_IRQ_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextWord <= NO_IRQ_WORD;
      extPend  <= 1'b0;
    end else begin
      nextWord <= wordNext;
      extPend  <= pendAny;
    end
  end

  assign clrIdx = strobes.clrForce ? nextWord[2 +: IDX_W] : '0;
endmodule

// File: rtl/irqsel_control.sv
module irqsel_control
  import irqsel_pkg::*;
(
  input  logic       readStb,
  input  logic       updateBit,
  input  logic       resultNone,
  output selStrobe_t strobes
);
  always_comb begin
    strobes.clrForce = readStb & ~resultNone;
    strobes.raise    = readStb & ~resultNone & updateBit;
  end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_IRQ-1:0]         pendVec,
  input  logic [NUM_IRQ-1:0]         enableVec,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prioVec,
  input  logic [PRIO_W-1:0]          curLevel,
  input  logic [PRIO_W-1:0]          prevLevel,
  input  logic                       readStb,
  input  logic                       updateBit,
  output logic                       extIrqPending,
  output logic [31:0]                nextWord,
  output logic                       forceClr,
  output logic [$clog2(NUM_IRQ)-1:0] forceClrIdx,
  output logic                       raiseLevel
);
  selStrobe_t strobes;

  irqsel_control u_ctrl (
    .readStb    (readStb),
    .updateBit  (updateBit),
    .resultNone (nextWord[31]),
    .strobes    (strobes)
  );

  irqsel_datapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pendVec   (pendVec),
    .enableVec (enableVec),
    .prioVec   (prioVec),
    .curLevel  (curLevel),
    .prevLevel (prevLevel),
    .strobes   (strobes),
    .nextWord  (nextWord),
    .extPend   (extIrqPending),
    .clrIdx    (forceClrIdx)
  );

  assign forceClr   = strobes.clrForce;
  assign raiseLevel = strobes.raise;
endmodule

// File: rtl/irqsel_checker.sv
module irqsel_checker #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_IRQ-1:0]         pendVec,
  input logic [NUM_IRQ-1:0]         enableVec,
  input logic [NUM_IRQ*PRIO_W-1:0]  prioVec,
  input logic [PRIO_W-1:0]          prevLevel,
  input logic                       readStb,
  input logic                       updateBit,
  input logic [31:0]                nextWord,
  input logic                       forceClr,
  input logic [$clog2(NUM_IRQ)-1:0] forceClrIdx,
  input logic                       raiseLevel
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  logic [IDX_W-1:0] winIdx;
  assign winIdx = nextWord[2 +: IDX_W];

  // R6
  no_irq_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextWord[31] |-> (nextWord[30:0] == 31'd0));

  // R5
  word_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nextWord[31] |-> ((nextWord[1:0] == 2'b00) && ((nextWord >> 2) < 32'(NUM_IRQ))));

  // R1
  winner_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nextWord[31] |-> ((($past(pendVec & enableVec) >> winIdx) & NUM_IRQ'(1)) != '0));

  // R3
  winner_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nextWord[31] |-> (PRIO_W'($past(prioVec) >> (int'(winIdx) * PRIO_W)) >= $past(prevLevel)));

  // R7
  force_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceClr |-> (readStb && !nextWord[31] && (forceClrIdx == winIdx)));

  // R8
  raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    raiseLevel |-> (forceClr && updateBit));
endmodule

bind irqsel_top irqsel_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pendVec     (pendVec),
  .enableVec   (enableVec),
  .prioVec     (prioVec),
  .prevLevel   (prevLevel),
  .readStb     (readStb),
  .updateBit   (updateBit),
  .nextWord    (nextWord),
  .forceClr    (forceClr),
  .forceClrIdx (forceClrIdx),
  .raiseLevel  (raiseLevel)
);

// File: tb/tb_irqsel_top.sv
module tb_irqsel_top;
  localparam int NUM_IRQ = 32;
  localparam int PRIO_W  = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [31:0]  pendVec = '0, enableVec = '0;
  logic [127:0] prioVec = '0;
  logic [3:0]   curLevel = '0, prevLevel = '0;
  logic         readStb = 1'b0, updateBit = 1'b0;
  logic         extIrqPending, forceClr, raiseLevel;
  logic [31:0]  nextWord;
  logic [4:0]   forceClrIdx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irqsel_top #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) dut (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .enableVec(enableVec),
    .prioVec(prioVec), .curLevel(curLevel), .prevLevel(prevLevel),
    .readStb(readStb), .updateBit(updateBit), .extIrqPending(extIrqPending),
    .nextWord(nextWord), .forceClr(forceClr), .forceClrIdx(forceClrIdx),
    .raiseLevel(raiseLevel)
  );

  typedef struct packed {
    logic [31:0]  pend;
    logic [31:0]  en;
    logic [127:0] prio;
    logic [3:0]   cur;
    logic [3:0]   prev;
    logic [31:0]  expWord;
    logic         expFlag;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0, 32'hFFFF_FFFF, 128'h0, 4'd0, 4'd0, 32'h8000_0000, 1'b0},
    '{32'h10, 32'h0, 128'h0, 4'd0, 4'd0, 32'h8000_0000, 1'b0},
    '{32'h30, 32'h30, 128'h0, 4'd0, 4'd0, 32'h10, 1'b1},
    '{32'h30, 32'h30, 128'h30_0000, 4'd0, 4'd0, 32'h14, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 128'h2000_0000_0000_0000_0000_0000_0000_0000,
      4'd3, 4'd0, 32'h7C, 1'b0},
    '{32'h8000_0000, 32'h8000_0000, 128'h2000_0000_0000_0000_0000_0000_0000_0000,
      4'd2, 4'd3, 32'h8000_0000, 1'b1}
  };

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference scan
  task automatic refModel(output logic [31:0] expWord, output logic expFlag);
    int best = -1;
    int bestPrio = -1;
    expFlag = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      int p = int'(prioVec[i*4 +: 4]);
      if (pendVec[i] && enableVec[i]) begin
        if (p >= int'(curLevel)) expFlag = 1'b1;
        if (p >= int'(prevLevel) && p > bestPrio) begin
          best = i;
          bestPrio = p;
        end
      end
    end
    expWord = (best < 0) ? 32'h8000_0000 : (32'(best) << 2);
  endtask

  task automatic applyVec(input vec_t v);
    @(negedge clk);
    pendVec = v.pend; enableVec = v.en; prioVec = v.prio;
    curLevel = v.cur; prevLevel = v.prev;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ew;
    logic ef;
    // R9 reset state, inputs that would otherwise select a line
    pendVec = 32'h1; enableVec = 32'h1;
    repeat (3) @(negedge clk);
    checkEq("R9 word in reset", nextWord, 32'h8000_0000);
    checkEq("R9 flag in reset", 32'(extIrqPending), 32'd0);
    rstN = 1'b1;
    pendVec = '0; enableVec = '0;
    @(negedge clk);
    checkEq("R9 word after reset", nextWord, 32'h8000_0000);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      applyVec(VECS[i]);
      checkEq($sformatf("R4/R5/R6/R3 vector %0d word", i), nextWord, VECS[i].expWord);
      checkEq($sformatf("R2/R1 vector %0d flag", i), 32'(extIrqPending), 32'(VECS[i].expFlag));
    end

    // R7 read on no-irq result (vector 5 still applied)
    readStb = 1'b1; updateBit = 1'b1; #1;
    checkEq("R7 no clear on empty read", 32'(forceClr), 32'd0);
    checkEq("R7 index zero on empty read", 32'(forceClrIdx), 32'd0);
    checkEq("R8 no raise on empty read", 32'(raiseLevel), 32'd0);
    readStb = 1'b0; updateBit = 1'b0;

    // R7/R8 read on valid result (irq 5)
    applyVec(VECS[3]);
    readStb = 1'b1; #1;
    checkEq("R7 clear pulse", 32'(forceClr), 32'd1);
    checkEq("R7 clear index", 32'(forceClrIdx), 32'd5);
    checkEq("R8 no raise without update", 32'(raiseLevel), 32'd0);
    updateBit = 1'b1; #1;
    checkEq("R8 raise with update", 32'(raiseLevel), 32'd1);
    readStb = 1'b0; #1;
    checkEq("R8 update alone no raise", 32'(raiseLevel), 32'd0);
    checkEq("R7 idle no clear", 32'(forceClr), 32'd0);
    updateBit = 1'b0;

    // R4 tie at non-zero priority: lines 3 and 9 both at 7, line 1 at 6
    @(negedge clk);
    pendVec = 32'h20A; enableVec = 32'h20A;
    prioVec = '0;
    prioVec[3*4 +: 4] = 4'd7; prioVec[9*4 +: 4] = 4'd7; prioVec[1*4 +: 4] = 4'd6;
    curLevel = 4'd0; prevLevel = 4'd0;
    @(negedge clk);
    checkEq("R4 tie lowest index", nextWord, 32'hC);

    // random patterns against the reference scan: R1 R2 R3 R4 R5 R6
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      pendVec = $urandom; enableVec = $urandom;
      prioVec = {$urandom, $urandom, $urandom, $urandom};
      curLevel = 4'($urandom); prevLevel = 4'($urandom);
      if (n % 4 == 0) prevLevel = 4'd0;
      @(negedge clk);
      refModel(ew, ef);
      checkEq("R3/R4/R5/R6 random word", nextWord, ew);
      checkEq("R1/R2 random flag", 32'(extIrqPending), 32'(ef));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule